// File: doc/BRIEF.md
# Skip-Sequence Up/Down Counter

A three-bit synchronous counter whose behaviour is chosen each cycle by a two-bit select. It can freeze its value, take a new value from a three-bit parallel input, step upward through the six-value ring 0, 1, 2, 5, 6, 7, or step downward through the same ring in reverse. The values 3 and 4 are never produced by a counting step. In either direction, the step between 2 and 5 is a single clock.

The counter is built as a plain counter core with enable, load and direction controls. A small decoder drives that core from the select. A step stage bends the core's ordinary increment and decrement so that they jump over the two skipped codes. An active-high reset clears the count to zero at once, without waiting for a clock edge, and it overrides any select value.

Top module: `skip_counter`

## Requirements
- R1: While `rst` is 1 the output `q` is 000, and it becomes 000 as soon as `rst` rises, with no clock edge needed.
- R2: With `sel` = 2'b00 (hold), `q` keeps its value across the clock edge.
- R3: With `sel` = 2'b01 (load), `q` takes the value of `din` at the clock edge.
- R4: With `sel` = 2'b10 (up), `q` steps 0→1→2→5→6→7, and 7 steps to 0.
- R5: Counting up from 2 gives 5 in one edge.
- R6: With `sel` = 2'b11 (down), `q` steps 7→6→5→2→1→0, and 0 steps to 7.
- R7: Counting down from 5 gives 2 in one edge.
- R8: If `q` holds 3 or 4 (after a load), an up step gives 5 and a down step gives 2. No counting step ever produces 3 or 4.
- R9: Reset wins over every `sel` value. While `rst` is 1, no mode changes `q` away from 000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Asynchronous active-high reset to 000 |
| sel | input | 2 | Mode select: 00 hold, 01 load, 10 up, 11 down |
| din | input | 3 | Parallel load value |
| q | output | 3 | Present count |

## Verification
`q` comes straight from a single register. Every hold, load or counting result therefore appears one rising edge after the select and data are applied. The only exception is reset, which takes effect with no edge at all. The bench applies inputs on the falling edge and reads `q` one nanosecond after the next rising edge, so each check sees exactly one step of the reference sequence. The asynchronous reset is raised in the middle of a cycle, and `q` is read before any further rising edge arrives.

// File: rtl/skipcnt_pkg.sv
package skipcnt_pkg;

    localparam int CNT_W   = 3;
    localparam int SKIP_LO = 3;
    localparam int SKIP_HI = 4;

    typedef logic [CNT_W-1:0] count_t;

    typedef enum logic [1:0] {
        MODE_HOLD = 2'b00,
        MODE_LOAD = 2'b01,
        MODE_UP   = 2'b10,
        MODE_DOWN = 2'b11
    } mode_e;

    typedef struct packed {
        logic en;
        logic ld;
        logic dn;
    } core_ctrl_t;

    // increment that jumps over the skipped band (and off it)
    function automatic count_t skip_inc(input count_t v);
        if (v >= count_t'(SKIP_LO - 1) && v <= count_t'(SKIP_HI))
            return count_t'(SKIP_HI + 1);
        return v + count_t'(1);
    endfunction

    // decrement that jumps over the skipped band (and off it)
    function automatic count_t skip_dec(input count_t v);
        if (v >= count_t'(SKIP_LO) && v <= count_t'(SKIP_HI + 1))
            return count_t'(SKIP_LO - 1);
        return v - count_t'(1);
    endfunction

endpackage

// File: rtl/skipcnt_decode.sv
module skipcnt_decode
    import skipcnt_pkg::*;
(
    input  logic [1:0] sel,
    output core_ctrl_t ctrl
);
    mode_e mode;

    always_comb begin
        mode = mode_e'(sel);
        ctrl = '0;
        unique case (mode)
            MODE_HOLD: ctrl = '{en: 1'b0, ld: 1'b0, dn: 1'b0};
            MODE_LOAD: ctrl = '{en: 1'b1, ld: 1'b1, dn: 1'b0};
            MODE_UP:   ctrl = '{en: 1'b1, ld: 1'b0, dn: 1'b0};
            MODE_DOWN: ctrl = '{en: 1'b1, ld: 1'b0, dn: 1'b1};
            default:   ctrl = '0;
        endcase
    end
endmodule

// File: rtl/skipcnt_step.sv
module skipcnt_step
    import skipcnt_pkg::*;
(
    input  count_t     cur,
    input  count_t     load_val,
    input  core_ctrl_t ctrl,
    output count_t     nxt
);
    count_t up_val;
    count_t dn_val;

    always_comb begin
        up_val = skip_inc(cur);
        dn_val = skip_dec(cur);
        if (!ctrl.en)
            nxt = cur;
        else if (ctrl.ld)
            nxt = load_val;
        else if (ctrl.dn)
            nxt = dn_val;
        else
            nxt = up_val;
    end
endmodule

// File: rtl/skipcnt_reg.sv
module skipcnt_reg
    import skipcnt_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  count_t d,
    output count_t q
);
    always_ff @(posedge clk or posedge rst) begin
        if (rst)
            q <= '0;
        else
            q <= d;
    end
endmodule

// File: rtl/skip_counter.sv
module skip_counter
    import skipcnt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] sel,
    input  logic [2:0] din,
    output logic [2:0] q
);
    core_ctrl_t ctrl;
    count_t     nxt;
    count_t     cnt;

    skipcnt_decode u_dec (
        .sel  (sel),
        .ctrl (ctrl)
    );

    skipcnt_step u_step (
        .cur      (cnt),
        .load_val (count_t'(din)),
        .ctrl     (ctrl),
        .nxt      (nxt)
    );

    skipcnt_reg u_reg (
        .clk (clk),
        .rst (rst),
        .d   (nxt),
        .q   (cnt)
    );

    assign q = cnt;
endmodule

// File: rtl/skip_counter_chk.sv
module skip_counter_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] sel,
    input logic [2:0] din,
    input logic [2:0] q
);
    logic past_ok;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    // R1 R9
    reset_zero_chk: assert property (@(posedge clk) rst |-> q == 3'd0);

    // R2
    hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(sel) == 2'b00) |-> $stable(q));

    // R3
    load_take_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(sel) == 2'b01) |-> q == $past(din));

    // R5
    up_jump_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(sel) == 2'b10 && $past(q) == 3'd2) |-> q == 3'd5);

    // R7
    down_jump_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(sel) == 2'b11 && $past(q) == 3'd5) |-> q == 3'd2);

    // R8
    no_skipped_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(sel[1])) |-> (q != 3'd3 && q != 3'd4));

    // R4
    up_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(sel) == 2'b10 && $past(q) == 3'd7) |-> q == 3'd0);

    // R6
    down_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(sel) == 2'b11 && $past(q) == 3'd0) |-> q == 3'd7);
endmodule

bind skip_counter skip_counter_chk u_chk (
    .clk (clk),
    .rst (rst),
    .sel (sel),
    .din (din),
    .q   (q)
);

// File: tb/skip_counter_test.sv
`timescale 1ns/1ps
module skip_counter_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] sel = 2'b00;
    logic [2:0] din = 3'd0;
    logic [2:0] q;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    skip_counter uut (.clk(clk), .rst(rst), .sel(sel), .din(din), .q(q));

    function automatic logic [2:0] ref_up(input logic [2:0] v);
        case (v)
            3'd0: return 3'd1;
            3'd1: return 3'd2;
            3'd2, 3'd3, 3'd4: return 3'd5;
            3'd5: return 3'd6;
            3'd6: return 3'd7;
            default: return 3'd0;
        endcase
    endfunction

    function automatic logic [2:0] ref_dn(input logic [2:0] v);
        case (v)
            3'd7: return 3'd6;
            3'd6: return 3'd5;
            3'd5, 3'd4, 3'd3: return 3'd2;
            3'd2: return 3'd1;
            3'd1: return 3'd0;
            default: return 3'd7;
        endcase
    endfunction

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: q=%0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input logic [1:0] s, input logic [2:0] d);
        @(negedge clk);
        sel = s;
        din = d;
        @(posedge clk);
        #1;
    endtask

    task automatic do_load(input logic [2:0] v);
        step(2'b01, v);
        check("R3", q, v);
    endtask

    task automatic t_reset;
        check("R1", q, 3'd0);
        @(negedge clk);
        rst = 1'b0;
        #1 check("R1", q, 3'd0);
    endtask

    task automatic t_hold;
        do_load(3'd6);
        for (int i = 0; i < 3; i++) begin
            step(2'b00, 3'd1);
            check("R2", q, 3'd6);
        end
    endtask

    task automatic t_load;
        for (int v = 0; v < 8; v++) do_load(3'(v));
    endtask

    task automatic t_up;
        logic [2:0] e;
        do_load(3'd0);
        e = 3'd0;
        for (int i = 0; i < 7; i++) begin
            e = ref_up(e);
            step(2'b10, 3'd3);
            check(e == 3'd5 ? "R5" : "R4", q, e);
        end
    endtask

    task automatic t_down;
        logic [2:0] e;
        do_load(3'd7);
        e = 3'd7;
        for (int i = 0; i < 7; i++) begin
            e = ref_dn(e);
            step(2'b11, 3'd4);
            check(e == 3'd2 ? "R7" : "R6", q, e);
        end
    endtask

    task automatic t_offseq;
        do_load(3'd3); step(2'b10, 3'd0); check("R8", q, 3'd5);
        do_load(3'd4); step(2'b10, 3'd0); check("R8", q, 3'd5);
        do_load(3'd3); step(2'b11, 3'd0); check("R8", q, 3'd2);
        do_load(3'd4); step(2'b11, 3'd0); check("R8", q, 3'd2);
    endtask

    task automatic t_reset_prio;
        for (int m = 0; m < 4; m++) begin
            do_load(3'd6);
            @(negedge clk);
            sel = 2'(m);
            din = 3'd7;
            #0.5 rst = 1'b1;
            #0.5 check("R1", q, 3'd0);
            @(posedge clk);
            #1 check("R9", q, 3'd0);
            @(posedge clk);
            #1 check("R9", q, 3'd0);
            @(negedge clk);
            sel = 2'b00;
            rst = 1'b0;
        end
    endtask

    initial begin
        t_reset();
        t_hold();
        t_load();
        t_up();
        t_down();
        t_offseq();
        t_reset_prio();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule